// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is a 24-pin general-purpose port, split into three banks of eight pins, that sits behind a byte-wide register bus of the kind a serial-to-register bridge presents (address, write data, write strobe, read strobe, read data). Software configures each pin through three configuration bytes per bank (direction, type, pull) and moves output levels only through dedicated set and clear addresses, so that a single write can raise or lower any subset of a bank without a read-modify-write.

The block turns each pin's configuration into pad-control signals: output enable, output level, open-drain select, pull-up, pull-down and an analog select. The type and pull bits are shared between the two directions and decoded differently for input and output pins. Pin levels come back through a two-flop synchronizer into read-only level registers. The upper bank is split into two half-groups that each have an enable input; while a half-group is disabled its configuration is still written and kept, but its pads are released.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every direction, type, pull and output-latch bit is 0 and all these registers read 0, so with both group enables on every pin shows pad_ana=1 and all other pad outputs 0.
- R2: Pin n is bit n%8 of bank n/8; the direction bytes sit at 0x60, 0x61, 0x62, read back as written, and a direction bit of 1 sets that pin's pad_oe while 0 clears it.
- R3: Writing the set bytes at 0x6C, 0x6D, 0x6E sets the output-latch bits written as 1 and leaves bits written as 0 unchanged.
- R4: Writing the clear bytes at 0x70, 0x71, 0x72 clears the output-latch bits written as 1 and leaves bits written as 0 unchanged.
- R5: Reading a set or clear address returns the output latch of that bank.
- R6: For an output pin (direction 1), pad_out equals the latch bit; type byte (0x64..0x66) bit 0 gives push-pull (pad_od=0, no pulls) and 1 gives open-drain (pad_od=1), where the pull byte (0x68..0x6A) bit enables pad_pu.
- R7: For an input pin (direction 0) the (type, pull) pair selects analog (0,0) with pad_ana=1, floating (0,1) with no pad control set, pull-down (1,0) with pad_pd=1, pull-up (1,1) with pad_pu=1; pad_oe, pad_out and pad_od stay 0.
- R8: The level bytes at 0x10, 0x11, 0x12 return pin_in through two synchronizer flops: a read whose strobe edge is the first or second edge after a pin change returns the old level, from the third edge on the new level; writes to these addresses have no effect.
- R9: Pins 16..19 are active only while grp_lo_en is 1 and pins 20..23 only while grp_hi_en is 1; a disabled pin has all six pad outputs at 0, and its configuration and latch written meanwhile are kept and take effect once enabled. Pins 0..15 are always active.
- R10: Addresses outside the mapped bytes (for example 0x00, 0x13, 0x63, 0x73) read as 0 and writes to them change no register.
- R11: bus_rdata is loaded on the clock edge at which bus_re is 1 and holds its value on every other edge; it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| grp_lo_en | input | 1 | Enable for pins 16..19 |
| grp_hi_en | input | 1 | Enable for pins 20..23 |
| pin_in | input | 24 | Asynchronous pin levels from the pads |
| pad_oe | output | 24 | Driver enable per pin |
| pad_out | output | 24 | Driven level per pin |
| pad_od | output | 24 | Open-drain select per pin |
| pad_pu | output | 24 | Pull-up enable per pin |
| pad_pd | output | 24 | Pull-down enable per pin |
| pad_ana | output | 24 | Analog mode select per pin |

## Verification
The pad outputs are a combinational function of the stored bits, so a wrong direction, type, pull or latch bit appears on the pad vectors in the same cycle the write lands, and a write that strays to the wrong bank shows up on another bank's pins at once. A latch that mishandles the set or clear masking is visible both on pad_out and on the next read of either latch address. A synchronizer of the wrong depth shifts the cycle at which a level read flips, which is checked edge by edge, and a half-group whose enable is misrouted shows as pad activity on pins that must be released.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // Register groups the address decoder can select
   typedef enum logic [2:0] {
      GRP_NONE,
      GRP_LEVEL,
      GRP_DIR,
      GRP_TYPE,
      GRP_PULL,
      GRP_SET,
      GRP_CLR
   } reg_grp_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
   import gpio_port_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int NUM_BANKS  = 3,
   parameter int BIDX_W     = 2,
   parameter int LEVEL_BASE = 'h10,
   parameter int DIR_BASE   = 'h60,
   parameter int TYPE_BASE  = 'h64,
   parameter int PULL_BASE  = 'h68,
   parameter int SET_BASE   = 'h6C,
   parameter int CLR_BASE   = 'h70
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_grp_e          grp,
   output logic [BIDX_W-1:0] bank
);

   always_comb begin
      grp  = GRP_NONE;
      bank = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (addr == ADDR_W'(LEVEL_BASE + b)) begin
            grp = GRP_LEVEL; bank = BIDX_W'(b);
         end
         if (addr == ADDR_W'(DIR_BASE + b)) begin
            grp = GRP_DIR; bank = BIDX_W'(b);
         end
         if (addr == ADDR_W'(TYPE_BASE + b)) begin
            grp = GRP_TYPE; bank = BIDX_W'(b);
         end
         if (addr == ADDR_W'(PULL_BASE + b)) begin
            grp = GRP_PULL; bank = BIDX_W'(b);
         end
         if (addr == ADDR_W'(SET_BASE + b)) begin
            grp = GRP_SET; bank = BIDX_W'(b);
         end
         if (addr == ADDR_W'(CLR_BASE + b)) begin
            grp = GRP_CLR; bank = BIDX_W'(b);
         end
      end
   end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 24,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_dir,
   input  logic         we_type,
   input  logic         we_pull,
   input  logic         we_set,
   input  logic         we_clr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] dir,
   output logic [W-1:0] typ,
   output logic [W-1:0] pull,
   output logic [W-1:0] lat
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir  <= '0;
         typ  <= '0;
         pull <= '0;
         lat  <= '0;
      end else begin
         if (we_dir)  dir  <= wdata;
         if (we_type) typ  <= wdata;
         if (we_pull) pull <= wdata;
         if (we_set)      lat <= lat | wdata;
         else if (we_clr) lat <= lat & ~wdata;
      end
   end

endmodule

// File: rtl/gpio_pad_mode.sv
module gpio_pad_mode #(
   parameter int W = 8
) (
   input  logic [W-1:0] en,
   input  logic [W-1:0] dir,
   input  logic [W-1:0] typ,
   input  logic [W-1:0] pull,
   input  logic [W-1:0] lat,
   output logic [W-1:0] oe,
   output logic [W-1:0] out,
   output logic [W-1:0] od,
   output logic [W-1:0] pu,
   output logic [W-1:0] pd,
   output logic [W-1:0] ana
);

   // Type and pull are shared by both directions; direction picks the meaning
   assign oe  = en & dir;
   assign out = en & dir & lat;
   assign od  = en & dir & typ;
   assign pu  = en & typ & pull;
   assign pd  = en & ~dir & typ & ~pull;
   assign ana = en & ~dir & ~typ & ~pull;

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int NUM_BANKS   = 3,
   parameter int BANK_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int LEVEL_BASE  = 'h10,
   parameter int DIR_BASE    = 'h60,
   parameter int TYPE_BASE   = 'h64,
   parameter int PULL_BASE   = 'h68,
   parameter int SET_BASE    = 'h6C,
   parameter int CLR_BASE    = 'h70,
   localparam int NPINS      = NUM_BANKS * BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BANK_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [BANK_W-1:0] bus_rdata,
   input  logic              grp_lo_en,
   input  logic              grp_hi_en,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_od,
   output logic [NPINS-1:0]  pad_pu,
   output logic [NPINS-1:0]  pad_pd,
   output logic [NPINS-1:0]  pad_ana
);

   localparam int HALF   = BANK_W / 2;
   localparam int BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   // Elaboration-time configuration checks
   if (NUM_BANKS < 2 || (BANK_W % 2) != 0) begin : g_bad_geometry
      $error("gpio_port_regs: need two or more banks of even width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_port_regs: synchronizer needs at least two stages");
   end
   if (NPINS > (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_port_regs: address width too small");
   end

   reg_grp_e            sel_grp;
   logic [BIDX_W-1:0]   sel_bank;
   logic [NPINS-1:0]    lvl_q;
   logic [NPINS-1:0]    pin_en;
   logic [BANK_W-1:0]   dir_b  [NUM_BANKS];
   logic [BANK_W-1:0]   typ_b  [NUM_BANKS];
   logic [BANK_W-1:0]   pull_b [NUM_BANKS];
   logic [BANK_W-1:0]   lat_b  [NUM_BANKS];
   logic [BANK_W-1:0]   rd_mux;

   gpio_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BIDX_W(BIDX_W),
      .LEVEL_BASE(LEVEL_BASE), .DIR_BASE(DIR_BASE), .TYPE_BASE(TYPE_BASE),
      .PULL_BASE(PULL_BASE), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
   ) u_dec (
      .addr (bus_addr),
      .grp  (sel_grp),
      .bank (sel_bank)
   );

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (lvl_q)
   );

   // Lower banks are always live; the top bank splits into two enabled halves
   assign pin_en = {{HALF{grp_hi_en}}, {HALF{grp_lo_en}}, {(NPINS - BANK_W){1'b1}}};

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit = bus_we && (sel_bank == BIDX_W'(b));

      gpio_bank_regs #(.W(BANK_W)) u_regs (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_dir  (hit && sel_grp == GRP_DIR),
         .we_type (hit && sel_grp == GRP_TYPE),
         .we_pull (hit && sel_grp == GRP_PULL),
         .we_set  (hit && sel_grp == GRP_SET),
         .we_clr  (hit && sel_grp == GRP_CLR),
         .wdata   (bus_wdata),
         .dir     (dir_b[b]),
         .typ     (typ_b[b]),
         .pull    (pull_b[b]),
         .lat     (lat_b[b])
      );

      gpio_pad_mode #(.W(BANK_W)) u_mode (
         .en   (pin_en [b*BANK_W +: BANK_W]),
         .dir  (dir_b[b]),
         .typ  (typ_b[b]),
         .pull (pull_b[b]),
         .lat  (lat_b[b]),
         .oe   (pad_oe [b*BANK_W +: BANK_W]),
         .out  (pad_out[b*BANK_W +: BANK_W]),
         .od   (pad_od [b*BANK_W +: BANK_W]),
         .pu   (pad_pu [b*BANK_W +: BANK_W]),
         .pd   (pad_pd [b*BANK_W +: BANK_W]),
         .ana  (pad_ana[b*BANK_W +: BANK_W])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (sel_bank == BIDX_W'(b)) begin
            case (sel_grp)
               GRP_LEVEL:        rd_mux = lvl_q[b*BANK_W +: BANK_W];
               GRP_DIR:          rd_mux = dir_b[b];
               GRP_TYPE:         rd_mux = typ_b[b];
               GRP_PULL:         rd_mux = pull_b[b];
               GRP_SET, GRP_CLR: rd_mux = lat_b[b];
               default:          rd_mux = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_re) bus_rdata <= rd_mux;
   end

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
   parameter int NUM_BANKS = 3,
   parameter int BANK_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int CLR_BASE  = 'h70,
   localparam int NPINS    = NUM_BANKS * BANK_W,
   localparam int HALF     = BANK_W / 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BANK_W-1:0] bus_wdata,
   input logic              bus_we,
   input logic              bus_re,
   input logic [BANK_W-1:0] bus_rdata,
   input logic              grp_lo_en,
   input logic              grp_hi_en,
   input logic [NPINS-1:0]  pad_oe,
   input logic [NPINS-1:0]  pad_out,
   input logic [NPINS-1:0]  pad_od,
   input logic [NPINS-1:0]  pad_pu,
   input logic [NPINS-1:0]  pad_pd,
   input logic [NPINS-1:0]  pad_ana
);

   logic [NPINS-1:0] any_ctl;
   assign any_ctl = pad_oe | pad_out | pad_od | pad_pu | pad_pd | pad_ana;

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> $stable(bus_rdata)) else $error("rdata moved without read"); // R11

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr == '0) |=> (bus_rdata == '0)) else $error("unmapped read nonzero"); // R10

   AST_CLR_DROPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(CLR_BASE) && bus_wdata[0]) |=> !pad_out[0])
      else $error("clear did not lower pin 0"); // R4

   AST_LO_GROUP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_lo_en |-> (any_ctl[NPINS-BANK_W +: HALF] == '0)) else $error("low group active"); // R9

   AST_HI_GROUP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_hi_en |-> (any_ctl[NPINS-1 -: HALF] == '0)) else $error("high group active"); // R9

   AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_pd) == '0) else $error("pull-up and pull-down together"); // R7

   AST_OD_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_od & ~pad_oe) == '0) else $error("open-drain on input pin"); // R6

   AST_ANALOG_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_ana & (pad_oe | pad_pu | pad_pd)) == '0) else $error("analog pin with drive or pull"); // R7

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
   .NUM_BANKS (NUM_BANKS),
   .BANK_W    (BANK_W),
   .ADDR_W    (ADDR_W),
   .CLR_BASE  (CLR_BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_we    (bus_we),
   .bus_re    (bus_re),
   .bus_rdata (bus_rdata),
   .grp_lo_en (grp_lo_en),
   .grp_hi_en (grp_hi_en),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out),
   .pad_od    (pad_od),
   .pad_pu    (pad_pu),
   .pad_pd    (pad_pd),
   .pad_ana   (pad_ana)
);

// File: tb/gpio_port_regs_tb_top.sv
module gpio_port_regs_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [7:0]  bus_rdata;
   logic        grp_lo_en = 1'b1;
   logic        grp_hi_en = 1'b1;
   logic [23:0] pin_in = '0;
   logic [23:0] pad_oe, pad_out, pad_od, pad_pu, pad_pd, pad_ana;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   // Bench model of the stored state
   logic [23:0] m_dir = '0, m_typ = '0, m_pull = '0, m_lat = '0;

   always #10 clk = ~clk;   // 50 MHz

   gpio_port_regs dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .grp_lo_en(grp_lo_en), .grp_hi_en(grp_hi_en), .pin_in(pin_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od),
      .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_ana(pad_ana)
   );

   task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   task automatic wr24(input logic [7:0] base, input logic [23:0] v);
      for (int b = 0; b < 3; b++) wr(base + 8'(b), v[b*8 +: 8]);
   endtask

   task automatic rd24(input logic [7:0] base, output logic [23:0] v);
      logic [7:0] t;
      for (int b = 0; b < 3; b++) begin
         rd(base + 8'(b), t);
         v[b*8 +: 8] = t;
      end
   endtask

   task automatic chk_pads(input string req);
      logic [23:0] en;
      en = {{4{grp_hi_en}}, {4{grp_lo_en}}, 16'hFFFF};
      chk({req, " oe"},  pad_oe,  en & m_dir);
      chk({req, " out"}, pad_out, en & m_dir & m_lat);
      chk({req, " od"},  pad_od,  en & m_dir & m_typ);
      chk({req, " pu"},  pad_pu,  en & m_typ & m_pull);
      chk({req, " pd"},  pad_pd,  en & ~m_dir & m_typ & ~m_pull);
      chk({req, " ana"}, pad_ana, en & ~m_dir & ~m_typ & ~m_pull);
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [23:0] v;
      logic [7:0]  t;
      logic [7:0]  t_hold;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1 rdata", {16'h0, bus_rdata}, 24'h0);
      chk_pads("R1");
      rd24(8'h60, v); chk("R1 dir", v, 24'h0);
      rd24(8'h64, v); chk("R1 type", v, 24'h0);
      rd24(8'h68, v); chk("R1 pull", v, 24'h0);
      rd24(8'h6C, v); chk("R1 latch", v, 24'h0);

      // R2: walking direction bit across all 24 pins
      for (int p = 0; p < 24; p++) begin
         m_dir = 24'(1) << p;
         wr24(8'h60, m_dir);
         chk("R2 walk oe", pad_oe, m_dir);
         rd(8'h60 + 8'(p / 8), t);
         chk("R2 dir readback", {16'h0, t}, {16'h0, 8'(1 << (p % 8))});
      end

      // R6 R7 R9 R5: swept patterns over all modes and enable combinations
      for (int k = 0; k < 16; k++) begin
         logic [31:0] h;
         h = (32'(k) + 32'd1) * 32'h9E3779B9;
         m_dir  = h[23:0];
         m_typ  = h[31:8] ^ 24'hA5C3E1;
         m_pull = (h[23:0] * 24'd7) ^ 24'h5B5B5B;
         m_lat  = h[27:4];
         grp_lo_en = k[0];
         grp_hi_en = k[1];
         wr24(8'h60, m_dir);
         wr24(8'h64, m_typ);
         wr24(8'h68, m_pull);
         wr24(8'h70, 24'hFFFFFF);
         wr24(8'h6C, m_lat);
         chk_pads("R6 R7 R9 sweep");
         rd24(8'h6C, v); chk("R5 set readback", v, m_lat);
         rd24(8'h70, v); chk("R5 clr readback", v, m_lat);
      end
      grp_lo_en = 1'b1; grp_hi_en = 1'b1;

      // R3 R4: partial set and clear masks
      m_dir = 24'hFFFFFF; m_typ = '0; m_pull = '0;
      wr24(8'h60, m_dir); wr24(8'h64, m_typ); wr24(8'h68, m_pull);
      wr24(8'h70, 24'hFFFFFF); m_lat = '0;
      wr(8'h6D, 8'h0A); m_lat[15:8] = 8'h0A;
      wr(8'h6D, 8'h41); m_lat[15:8] = m_lat[15:8] | 8'h41;
      chk("R3 set keeps zeros", pad_out, m_lat);
      wr(8'h71, 8'h03); m_lat[15:8] = m_lat[15:8] & ~8'h03;
      chk("R4 clear keeps zeros", pad_out, m_lat);
      rd(8'h71, t); chk("R4 latch readback", {16'h0, t}, {16'h0, 8'h48});
      wr(8'h72, 8'h00); wr(8'h6E, 8'h00);
      chk("R3 R4 zero masks", pad_out, m_lat);

      // R8: level registers through the synchronizer
      pin_in = 24'hC3A55A;
      repeat (4) @(negedge clk);
      rd24(8'h10, v); chk("R8 levels", v, 24'hC3A55A);
      @(negedge clk);
      pin_in = 24'h3C5AA5; bus_addr = 8'h10; bus_re = 1'b1;
      @(negedge clk); chk("R8 edge1 old", {16'h0, bus_rdata}, {16'h0, 8'h5A});
      @(negedge clk); chk("R8 edge2 old", {16'h0, bus_rdata}, {16'h0, 8'h5A});
      @(negedge clk); chk("R8 edge3 new", {16'h0, bus_rdata}, {16'h0, 8'hA5});
      bus_re = 1'b0;
      wr(8'h11, 8'hFF);
      rd(8'h11, t); chk("R8 write ignored", {16'h0, t}, {16'h0, 8'h5A});
      chk_pads("R8 no side effect");

      // R10: unmapped addresses
      wr(8'h00, 8'hFF); wr(8'h13, 8'hFF); wr(8'h63, 8'hFF); wr(8'h73, 8'hFF);
      chk_pads("R10 writes ignored");
      rd(8'h00, t); chk("R10 read 0x00", {16'h0, t}, 24'h0);
      rd(8'h13, t); chk("R10 read 0x13", {16'h0, t}, 24'h0);
      rd(8'h63, t); chk("R10 read 0x63", {16'h0, t}, 24'h0);
      rd(8'h73, t); chk("R10 read 0x73", {16'h0, t}, 24'h0);
      rd24(8'h60, v); chk("R10 dir intact", v, m_dir);

      // R9: configuration written while disabled is kept
      grp_lo_en = 1'b0; grp_hi_en = 1'b0;
      m_typ[23:16] = 8'hF0; m_pull[23:16] = 8'hFF;
      wr(8'h66, 8'hF0); wr(8'h6A, 8'hFF);
      wr(8'h6E, 8'hFF); m_lat[23:16] = 8'hFF;
      chk_pads("R9 both off");
      grp_lo_en = 1'b1;
      #1 chk_pads("R9 low on");
      grp_hi_en = 1'b1;
      #1 chk_pads("R9 both on");

      // R11: read data holds without a strobe
      rd(8'h66, t_hold);
      wr(8'h66, 8'h0F); m_typ[23:16] = 8'h0F;
      repeat (3) @(negedge clk);
      chk("R11 hold", {16'h0, bus_rdata}, {16'h0, 8'hF0});
      rd(8'h66, t); chk("R11 new read", {16'h0, t}, {16'h0, 8'h0F});

      finish_run();
   end

endmodule